// File: doc/BRIEF.md
# Grouped Interrupt Expansion Multiplexer

This block gathers peripheral interrupt lines into groups of eight and gives each group one request line toward the CPU. Every source has a sticky pending flag and an enable bit. Every group has an acknowledge bit. A group raises its CPU line only when an enabled source is pending and the acknowledge bit is clear. Raising the line also sets the acknowledge bit. Software must clear that bit before the group can raise another request.

After the CPU has taken an interrupt, it asks for a vector by naming a group. The block looks at the live pending and enable state of that group and picks the lowest-numbered source that is both pending and enabled. It returns the group and source index as the vector code and clears the winner's flag. The vector table itself is held outside the block.

Top module: `gie_mux`

## Requirements
- R1: Each group has eight sources, numbered 1 to 8. Source y of group g is input bit `src_req[g*8 + y - 1]`, and `vec_idx` reports it as the value y.
- R2: A source's flag is set on any clock edge where its request input is high. It stays set until it is cleared. If a set and a clear reach the same flag on the same edge, the set wins.
- R3: `cpu_irq[g]` rises only when group g has a source that is both flagged and enabled, and the group's acknowledge bit is clear. A flagged source whose enable is 0 raises nothing.
- R4: When `cpu_irq[g]` pulses, the group's acknowledge bit is set on the same edge. While that bit stays set, the group raises no further pulse.
- R5: The request is a single-cycle pulse. It appears on the second edge after a request input is sampled: the flag registers on the first edge and the pulse on the second.
- R6: A write with `wr_sel`=2 clears the acknowledge bit of every group g for which `wr_data[g]` is 1. If the group still has an enabled pending source, a new pulse follows one edge after the write.
- R7: A fetch (`vec_req` high for one cycle with `vec_grp`) gives `vec_ack`=1 on the next cycle. `vec_grp_out` echoes the group, and `vec_idx` holds the lowest-numbered source of that group that is both flagged and enabled at fetch time. `vec_hit` is 1 in that case.
- R8: A fetch that finds a winner clears only that source's flag. All other flags are left as they were.
- R9: A fetch that finds no flagged and enabled source returns `vec_hit`=0 and `vec_idx`=0, and it clears no flag.
- R10: A write with `wr_sel`=0 replaces the enable byte of group `wr_grp` with `wr_data`, where bit y-1 belongs to source y. A write with `wr_sel`=1 clears the flags of group `wr_grp` wherever `wr_data` has a 1.
- R11: A request that arrives while the acknowledge bit is set still sets its flag. That flag is forwarded once the acknowledge bit is cleared.
- R12: Reset (synchronous, active high) clears all flags, enables and acknowledge bits, and sets all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_GROUPS*8 | Request lines from the sources |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 sets enables, 1 clears flags, 2 clears acknowledge bits |
| wr_grp | input | clog2(NUM_GROUPS) | Group addressed by the enable write and the flag-clear write |
| wr_data | input | 8 | Write data (a bit mask) |
| cpu_irq | output | NUM_GROUPS | One request pulse per group toward the CPU |
| vec_req | input | 1 | Vector fetch strobe |
| vec_grp | input | clog2(NUM_GROUPS) | Group whose vector is fetched |
| vec_ack | output | 1 | Fetch response valid |
| vec_hit | output | 1 | 1 if a source won the fetch |
| vec_grp_out | output | clog2(NUM_GROUPS) | Group of the returned vector |
| vec_idx | output | 4 | Winning source 1 to 8, or 0 if there is none |

## Verification
Two things can reach the same flag on the same edge: the automatic clear from a vector fetch and a fresh request from that same source. The bench holds a source's request high during the cycle in which the fetch picks that source. It then fetches again and expects the same index to come back, which shows that the set won over the clear. A second collision is an acknowledge-clear write that lands while a flag is still pending. Here the bench expects the group's line to stay low on the write edge and to pulse exactly once on the edge after it.

// File: rtl/gie_pkg.sv
package gie_pkg;

    localparam int SRC_PER_GRP = 8;
    localparam int IDX_W       = 4;

    typedef enum logic [1:0] {
        WSEL_ENABLE   = 2'd0,
        WSEL_FLAG_CLR = 2'd1,
        WSEL_ACK_CLR  = 2'd2,
        WSEL_RSVD     = 2'd3
    } wsel_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // lowest-numbered pending source wins; index is 1-based
    function automatic pick_t first_pending(input logic [SRC_PER_GRP-1:0] pend);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = SRC_PER_GRP - 1; i >= 0; i--) begin
            if (pend[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i + 1);
            end
        end
        return r;
    endfunction

    function automatic logic [SRC_PER_GRP-1:0] idx_to_mask(input logic [IDX_W-1:0] idx);
        logic [SRC_PER_GRP-1:0] m;
        m = '0;
        for (int i = 0; i < SRC_PER_GRP; i++) begin
            if (idx == IDX_W'(i + 1)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gie_wr_decode.sv
module gie_wr_decode
    import gie_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GW         = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [GW-1:0]          wr_grp,
    input  logic [7:0]             wr_data,
    output logic [NUM_GROUPS-1:0]  en_we,
    output logic [NUM_GROUPS-1:0]  fclr_we,
    output logic [NUM_GROUPS-1:0]  ack_clr
);

    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
        assign en_we[g]   = wr_en && (sel == WSEL_ENABLE)   && (wr_grp == GW'(g));
        assign fclr_we[g] = wr_en && (sel == WSEL_FLAG_CLR) && (wr_grp == GW'(g));
        assign ack_clr[g] = wr_en && (sel == WSEL_ACK_CLR)  && wr_data[g];
    end

    a_r10_single_group_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en_we | fclr_we));

endmodule

// File: rtl/gie_group.sv
module gie_group
    import gie_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SRC_PER_GRP-1:0] src_req,
    input  logic                   en_we,
    input  logic                   fclr_we,
    input  logic                   ack_clr,
    input  logic [7:0]             wr_data,
    input  logic [SRC_PER_GRP-1:0] fetch_mask,
    output logic                   irq,
    output logic [SRC_PER_GRP-1:0] pend
);

    logic [SRC_PER_GRP-1:0] flag_q;
    logic [SRC_PER_GRP-1:0] en_q;
    logic [SRC_PER_GRP-1:0] sw_clr;
    logic                   ack_q;
    logic                   irq_q;
    logic                   fwd;

    assign pend   = flag_q & en_q;
    assign fwd    = (|pend) && !ack_q;
    assign sw_clr = fclr_we ? wr_data : '0;
    assign irq    = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            ack_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            // a new request dominates any clear on the same edge
            flag_q <= (flag_q & ~sw_clr & ~fetch_mask) | src_req;
            if (en_we) en_q <= wr_data;
            if (fwd)          ack_q <= 1'b1;
            else if (ack_clr) ack_q <= 1'b0;
            irq_q <= fwd;
        end
    end

    a_r2_flag_latches: assert property (@(posedge clk) disable iff (rst)
        (|src_req) |=> ((flag_q & $past(src_req)) == $past(src_req)));

    a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(|pend) && !$past(ack_q)));

    a_r4_irq_sets_ack: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ack_q);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

endmodule

// File: rtl/gie_vec_unit.sv
module gie_vec_unit
    import gie_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GW         = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              vec_req,
    input  logic [GW-1:0]                     vec_grp,
    input  logic [NUM_GROUPS*SRC_PER_GRP-1:0] pend_all,
    output logic [NUM_GROUPS*SRC_PER_GRP-1:0] fetch_mask_all,
    output logic                              vec_ack,
    output logic                              vec_hit,
    output logic [GW-1:0]                     vec_grp_out,
    output logic [IDX_W-1:0]                  vec_idx
);

    logic [SRC_PER_GRP-1:0] sel_pend;
    pick_t                  pick;
    logic [SRC_PER_GRP-1:0] win_mask;

    always_comb begin
        sel_pend = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (vec_grp == GW'(g)) sel_pend = pend_all[g*SRC_PER_GRP +: SRC_PER_GRP];
        end
    end

    assign pick     = first_pending(sel_pend);
    assign win_mask = idx_to_mask(pick.idx);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_clr
        assign fetch_mask_all[g*SRC_PER_GRP +: SRC_PER_GRP] =
            (vec_req && (vec_grp == GW'(g))) ? win_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_ack     <= 1'b0;
            vec_hit     <= 1'b0;
            vec_grp_out <= '0;
            vec_idx     <= '0;
        end else begin
            vec_ack     <= vec_req;
            vec_hit     <= vec_req && pick.hit;
            vec_grp_out <= vec_req ? vec_grp : '0;
            vec_idx     <= vec_req ? pick.idx : '0;
        end
    end

    a_r8_one_clear_per_fetch: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fetch_mask_all));

    a_r7_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
        vec_ack |-> $past(vec_req));

    a_r7_hit_index_range: assert property (@(posedge clk) disable iff (rst)
        vec_hit |-> (vec_ack && vec_idx != '0 && vec_idx <= IDX_W'(SRC_PER_GRP)));

    a_r9_miss_zero_index: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && !vec_hit) |-> (vec_idx == '0));

endmodule

// File: rtl/gie_mux.sv
module gie_mux
    import gie_pkg::*;
#(
    parameter  int NUM_GROUPS = 4,
    localparam int GW         = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int NSRC       = NUM_GROUPS * SRC_PER_GRP
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        src_req,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [GW-1:0]          wr_grp,
    input  logic [7:0]             wr_data,
    output logic [NUM_GROUPS-1:0]  cpu_irq,
    input  logic                   vec_req,
    input  logic [GW-1:0]          vec_grp,
    output logic                   vec_ack,
    output logic                   vec_hit,
    output logic [GW-1:0]          vec_grp_out,
    output logic [IDX_W-1:0]       vec_idx
);

    logic [NUM_GROUPS-1:0] en_we;
    logic [NUM_GROUPS-1:0] fclr_we;
    logic [NUM_GROUPS-1:0] ack_clr;
    logic [NSRC-1:0]       pend_all;
    logic [NSRC-1:0]       fetch_mask_all;

    gie_wr_decode #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_grp  (wr_grp),
        .wr_data (wr_data),
        .en_we   (en_we),
        .fclr_we (fclr_we),
        .ack_clr (ack_clr)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        gie_group u_grp (
            .clk        (clk),
            .rst        (rst),
            .src_req    (src_req[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .en_we      (en_we[g]),
            .fclr_we    (fclr_we[g]),
            .ack_clr    (ack_clr[g]),
            .wr_data    (wr_data),
            .fetch_mask (fetch_mask_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .irq        (cpu_irq[g]),
            .pend       (pend_all[g*SRC_PER_GRP +: SRC_PER_GRP])
        );
    end

    gie_vec_unit #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_vec (
        .clk            (clk),
        .rst            (rst),
        .vec_req        (vec_req),
        .vec_grp        (vec_grp),
        .pend_all       (pend_all),
        .fetch_mask_all (fetch_mask_all),
        .vec_ack        (vec_ack),
        .vec_hit        (vec_hit),
        .vec_grp_out    (vec_grp_out),
        .vec_idx        (vec_idx)
    );

endmodule

// File: tb/sim_gie_mux.sv
module sim_gie_mux;

    localparam int NG   = 4;
    localparam int GW   = 2;
    localparam int NSRC = NG * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_req = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = 2'd3;
    logic [GW-1:0]   wr_grp = '0;
    logic [7:0]      wr_data = '0;
    logic [NG-1:0]   cpu_irq;
    logic            vec_req = 1'b0;
    logic [GW-1:0]   vec_grp = '0;
    logic            vec_ack;
    logic            vec_hit;
    logic [GW-1:0]   vec_grp_out;
    logic [3:0]      vec_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gie_mux #(.NUM_GROUPS(NG)) u0 (
        .clk(clk), .rst(rst), .src_req(src_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_grp(wr_grp), .wr_data(wr_data),
        .cpu_irq(cpu_irq), .vec_req(vec_req), .vec_grp(vec_grp),
        .vec_ack(vec_ack), .vec_hit(vec_hit), .vec_grp_out(vec_grp_out),
        .vec_idx(vec_idx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input int g, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_grp = GW'(g); wr_data = d;
        tick();
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic raise(input int g, input logic [7:0] m);
        src_req[g*8 +: 8] = m;
        tick();
        src_req = '0;
    endtask

    task automatic fetch(input int g, input bit eh, input int ei, input string tag);
        vec_req = 1'b1; vec_grp = GW'(g);
        tick();
        vec_req = 1'b0;
        chk(vec_ack == 1'b1, {tag, " ack"}, int'(vec_ack), 1);
        chk(vec_hit == eh, {tag, " hit"}, int'(vec_hit), int'(eh));
        chk(int'(vec_idx) == ei, {tag, " idx"}, int'(vec_idx), ei);
        chk(int'(vec_grp_out) == g, {tag, " grp"}, int'(vec_grp_out), g);
    endtask

    function automatic int lowest(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) if (m[i]) lowest = i + 1;
        if (m == 0) lowest = 0;
    endfunction

    task automatic drain(input int g, input logic [7:0] p, input string tag);
        logic [7:0] q = p;
        while (q != 0) begin
            int w = lowest(q);
            fetch(g, 1'b1, w, tag);
            q[w-1] = 1'b0;
        end
        fetch(g, 1'b0, 0, {tag, " R9 miss"});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        chk(cpu_irq == '0, "R12 irq after reset", int'(cpu_irq), 0);
        chk(vec_ack == 1'b0, "R12 vec_ack after reset", int'(vec_ack), 0);
        fetch(0, 1'b0, 0, "R12 no flags after reset");

        // R1 R3 R5 R7 R8 R6: every source of every group
        for (int g = 0; g < NG; g++) begin
            wr(2'd0, g, 8'hFF);
            for (int y = 1; y <= 8; y++) begin
                src_req[g*8 + y - 1] = 1'b1;
                tick();
                src_req = '0;
                chk(cpu_irq == '0, "R5 no irq on flag edge", int'(cpu_irq), 0);
                tick();
                chk(cpu_irq == NG'(1 << g), "R1 R3 irq of group", int'(cpu_irq), 1 << g);
                tick();
                chk(cpu_irq == '0, "R5 pulse one cycle", int'(cpu_irq), 0);
                fetch(g, 1'b1, y, "R7 R1 single source vector");
                fetch(g, 1'b0, 0, "R8 flag cleared by fetch");
                wr(2'd2, 0, 8'(1 << g));
                tick();
                chk(cpu_irq == '0, "R6 no irq without pending", int'(cpu_irq), 0);
            end
        end

        // R7 R10 priority and enable masks
        for (int g = 0; g < NG; g++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] m = 8'((g * 37 + k * 53 + 11) ^ (k * 29));
                logic [7:0] e = 8'((g * 71 + k * 97 + 5));
                wr(2'd0, g, e);
                raise(g, m);
                drain(g, m & e, "R7 R10 priority enabled");
                wr(2'd0, g, 8'hFF);
                drain(g, m & ~e, "R10 disabled flags kept");
                wr(2'd2, 0, 8'(1 << g));
                tick(); tick();
                chk(cpu_irq == '0, "R6 idle after drain", int'(cpu_irq), 0);
            end
        end

        // R3 disabled source does not forward; R10 enable then forwards
        wr(2'd0, 1, 8'h00);
        raise(1, 8'h10);
        tick(); tick();
        chk(cpu_irq == '0, "R3 disabled source silent", int'(cpu_irq), 0);
        wr(2'd0, 1, 8'h10);
        tick();
        chk(cpu_irq == 4'b0010, "R3 R10 enable forwards", int'(cpu_irq), 2);
        fetch(1, 1'b1, 5, "R10 enabled source vector");
        wr(2'd2, 0, 8'h02);

        // R10 software flag clear
        wr(2'd0, 2, 8'h00);
        raise(2, 8'h0C);
        wr(2'd1, 2, 8'h04);
        wr(2'd0, 2, 8'hFF);
        tick();
        chk(cpu_irq == 4'b0100, "R10 remaining flag forwards", int'(cpu_irq), 4);
        fetch(2, 1'b1, 4, "R10 cleared flag skipped");
        fetch(2, 1'b0, 0, "R10 cleared flag gone");
        wr(2'd2, 0, 8'h04);

        // R4 R11 R6 acknowledge blocks; late request forwarded after clear
        wr(2'd0, 0, 8'hFF);
        raise(0, 8'h02);
        tick();
        chk(cpu_irq == 4'b0001, "R4 first irq", int'(cpu_irq), 1);
        fetch(0, 1'b1, 2, "R4 first vector");
        raise(0, 8'h20);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(cpu_irq == '0, "R4 R11 blocked while ack set", int'(cpu_irq), 0);
        end
        wr(2'd2, 0, 8'h01);
        chk(cpu_irq == '0, "R6 no irq on clear edge", int'(cpu_irq), 0);
        tick();
        chk(cpu_irq == 4'b0001, "R6 R11 irq after ack clear", int'(cpu_irq), 1);
        tick();
        chk(cpu_irq == '0, "R5 R4 second pulse single", int'(cpu_irq), 0);
        fetch(0, 1'b1, 6, "R11 latched flag vector");
        wr(2'd2, 0, 8'h01);

        // R2 R8 collision: fetch clear and new request on same source
        wr(2'd0, 3, 8'hFF);
        raise(3, 8'h41);
        src_req[3*8 + 0] = 1'b1;
        fetch(3, 1'b1, 1, "R8 collision vector");
        src_req = '0;
        fetch(3, 1'b1, 1, "R2 set wins over fetch clear");
        fetch(3, 1'b1, 7, "R8 other flag kept");
        fetch(3, 1'b0, 0, "R9 empty after collision");

        // R9 fetch on group with disabled pending flag clears nothing
        wr(2'd0, 3, 8'h00);
        raise(3, 8'h80);
        fetch(3, 1'b0, 0, "R9 miss on disabled flag");
        wr(2'd0, 3, 8'hFF);
        fetch(3, 1'b1, 8, "R9 flag survived miss");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule